// File: doc/BRIEF.md
# Serial Port Baud Tick Generator

This block turns the system clock into the two timing strobes a serial port needs. One strobe, the bit tick, marks each bit period. The other, the sample tick, paces the receiver's oversampling logic. A down-counter is loaded from a divisor made of a high byte and a low byte. Each time the counter reaches zero it emits one base tick. A prescaler then groups base ticks into sample ticks and bit ticks.

Two mode inputs pick the counter width and the overall ratio. The wide-mode input decides whether the high byte takes part in the divisor. Together with the fast-mode input it selects 64, 16 or 4 clocks per bit for each unit of (divisor + 1).

The register file that holds the divisor bytes is outside this block. It presents their contents as levels and pulses a load strobe whenever either byte is written. That strobe restarts the counter and the prescaler phase at once, so a new rate takes effect without waiting for the old period to end.

Top module: `baud_tick_gen`

## Requirements
- R1: With `wide_mode` = 1 the divisor D is `{div_hi, div_lo}`; with `wide_mode` = 0 D is `div_lo` alone and `div_hi` has no effect on any tick.
- R2: With the port running, the spacing between bit ticks is K*(D+1) clocks. K is 64 when `wide_mode` and `fast_mode` are both 0, 4 when both are 1, and 16 when exactly one of them is 1.
- R3: `bit_tick` is high for exactly one clock per bit period.
- R4: Sample ticks are spaced 4*(D+1) clocks apart when K = 64 and D+1 clocks apart when K is 16 or 4. This gives 16 sample ticks per bit period when K is 64 or 16, and 4 per bit period when K = 4.
- R5: Every cycle in which `bit_tick` is high also has `samp_tick` high.
- R6: A cycle with `div_load` high emits no tick and restarts the phase from the divisor inputs. The first sample tick follows the load cycle by exactly one sample spacing, and the first bit tick follows it by exactly K*(D+1) clocks.
- R7: While `rst` is high, or while `port_en` is low, both ticks stay low. When `port_en` rises with D >= 1, the first sample tick comes in the (sample spacing)-th enabled cycle and the first bit tick in the K*(D+1)-th enabled cycle, counting the rising cycle as the first.
- R8: A divisor change without `div_load` does not cut the running count short. The current base period ends on the old value, and the following one uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| port_en | input | 1 | Serial port enable; low holds the generator idle |
| div_load | input | 1 | One-cycle strobe: a divisor byte was written |
| wide_mode | input | 1 | 1: 16-bit divisor, 0: low byte only |
| fast_mode | input | 1 | Ratio select, combined with `wide_mode` |
| div_hi | input | 8 | Divisor high byte |
| div_lo | input | 8 | Divisor low byte |
| bit_tick | output | 1 | One-cycle strobe per bit period |
| samp_tick | output | 1 | One-cycle receiver sample strobe |

## Verification
The assertions assume that `div_load` is a single-cycle pulse from the register side. They also assume that the mode inputs and divisor bytes change only while the port is idle, in the cycle before a load, or (for R8) deliberately without a load. The phase checks do not survive an arbitrary mid-period mode flip.

The bench drives every input just after a rising edge and samples the ticks at the falling edge. Every mode and divisor change is followed by a load, except in the one scenario that exercises R8. Mode changes are never left unflagged while the bit-phase timing is being measured.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

  // Largest clock-to-bit ratio; sizes the prescale phase counter.
  localparam int unsigned RATIO_MAX = 64;

  typedef enum logic [1:0] {
    RATIO_X64 = 2'd0,
    RATIO_X16 = 2'd1,
    RATIO_X4  = 2'd2
  } ratio_e;

  // Both clear -> 64, both set -> 4, one set -> 16.
  function automatic ratio_e pick_ratio(input logic wide, input logic fast);
    case ({wide, fast})
      2'b00:   return RATIO_X64;
      2'b11:   return RATIO_X4;
      default: return RATIO_X16;
    endcase
  endfunction

  // Base ticks (each D+1 clocks) that make one bit.
  function automatic int unsigned base_per_bit(input ratio_e r);
    case (r)
      RATIO_X64: return 64;
      RATIO_X16: return 16;
      default:   return 4;
    endcase
  endfunction

  // Base ticks that make one receiver sample.
  function automatic int unsigned base_per_sample(input ratio_e r);
    return (r == RATIO_X64) ? 4 : 1;
  endfunction

endpackage

// File: rtl/bg_mode_decode.sv
module bg_mode_decode
  import baud_gen_pkg::*;
#(
  parameter int PRE_W = 6
) (
  input  logic             wide_mode,
  input  logic             fast_mode,
  output logic [PRE_W-1:0] bit_last,
  output logic [PRE_W-1:0] samp_mask
);

  ratio_e ratio;

  assign ratio     = pick_ratio(wide_mode, fast_mode);
  // Terminal phase of a bit, and the low-bit mask that marks a sample.
  assign bit_last  = PRE_W'(base_per_bit(ratio) - 1);
  assign samp_mask = PRE_W'(base_per_sample(ratio) - 1);

endmodule

// File: rtl/bg_div_counter.sv
module bg_div_counter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_en,
  input  logic              div_load,
  input  logic              wide_mode,
  input  logic [BYTE_W-1:0] div_hi,
  input  logic [BYTE_W-1:0] div_lo,
  output logic              base_tick
);

  localparam int DIV_W = 2 * BYTE_W;

  logic [DIV_W-1:0] div_sel;
  logic [DIV_W-1:0] cnt;
  logic             at_zero;

  assign div_sel   = wide_mode ? {div_hi, div_lo} : {{BYTE_W{1'b0}}, div_lo};
  assign at_zero   = (cnt == '0);
  assign base_tick = port_en && !rst && !div_load && at_zero;

  // Idle or load: hold the divisor; running: count down, reload at zero.
  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (!port_en || div_load || at_zero)
      cnt <= div_sel;
    else
      cnt <= cnt - 1'b1;
  end

  // R2: a running count steps down by one per clock
  p_count_down_r2: assert property (@(posedge clk) disable iff (rst)
    (port_en && !div_load && !at_zero) |=> (cnt == $past(cnt) - 1'b1));

  // R6: a load takes the divisor in the same edge
  p_reload_r6: assert property (@(posedge clk) disable iff (rst)
    (port_en && div_load) |=> (cnt == $past(div_sel)));

  // R8: natural wrap picks up whatever divisor is present at the tick
  p_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    base_tick |=> (cnt == $past(div_sel)));

endmodule

// File: rtl/bg_prescale.sv
module bg_prescale #(
  parameter int PRE_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             port_en,
  input  logic             div_load,
  input  logic             base_tick,
  input  logic [PRE_W-1:0] bit_last,
  input  logic [PRE_W-1:0] samp_mask,
  output logic             bit_tick,
  output logic             samp_tick
);

  logic [PRE_W-1:0] phase;
  logic             wrap;

  // ">=" keeps the phase bounded if the ratio shrinks mid-bit.
  assign wrap      = (phase >= bit_last);
  assign bit_tick  = base_tick && wrap;
  assign samp_tick = base_tick && (wrap || ((phase & samp_mask) == samp_mask));

  always_ff @(posedge clk) begin
    if (rst || !port_en || div_load)
      phase <= '0;
    else if (base_tick)
      phase <= wrap ? '0 : phase + 1'b1;
  end

  // R5: a bit boundary is always a sample point
  p_bit_on_sample_r5: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> samp_tick);

  // R3: the bit strobe never lasts two cycles
  p_bit_single_r3: assert property (@(posedge clk) disable iff (rst)
    bit_tick |=> !bit_tick);

  // R6: a load restarts the bit phase
  p_phase_restart_r6: assert property (@(posedge clk) disable iff (rst)
    div_load |=> (phase == '0));

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_gen_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_en,
  input  logic              div_load,
  input  logic              wide_mode,
  input  logic              fast_mode,
  input  logic [BYTE_W-1:0] div_hi,
  input  logic [BYTE_W-1:0] div_lo,
  output logic              bit_tick,
  output logic              samp_tick
);

  localparam int PRE_W = $clog2(RATIO_MAX);

  logic             base_tick;
  logic [PRE_W-1:0] bit_last;
  logic [PRE_W-1:0] samp_mask;

  bg_mode_decode #(.PRE_W(PRE_W)) u_decode (
    .wide_mode (wide_mode),
    .fast_mode (fast_mode),
    .bit_last  (bit_last),
    .samp_mask (samp_mask)
  );

  bg_div_counter #(.BYTE_W(BYTE_W)) u_counter (
    .clk       (clk),
    .rst       (rst),
    .port_en   (port_en),
    .div_load  (div_load),
    .wide_mode (wide_mode),
    .div_hi    (div_hi),
    .div_lo    (div_lo),
    .base_tick (base_tick)
  );

  bg_prescale #(.PRE_W(PRE_W)) u_prescale (
    .clk       (clk),
    .rst       (rst),
    .port_en   (port_en),
    .div_load  (div_load),
    .base_tick (base_tick),
    .bit_last  (bit_last),
    .samp_mask (samp_mask),
    .bit_tick  (bit_tick),
    .samp_tick (samp_tick)
  );

  // R7: a disabled port is silent
  p_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !port_en |-> (!bit_tick && !samp_tick));

  // R3: a bit strobe only comes from a base period ending
  p_bit_from_base_r3: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> base_tick);

endmodule

// File: tb/baud_tick_gen_bench.sv
module baud_tick_gen_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       port_en = 1'b0;
  logic       div_load = 1'b0;
  logic       wide_mode = 1'b0;
  logic       fast_mode = 1'b0;
  logic [7:0] div_hi = 8'h00;
  logic [7:0] div_lo = 8'h00;
  logic       bit_tick;
  logic       samp_tick;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  baud_tick_gen #(.BYTE_W(8)) u_baud_tick_gen (
    .clk       (clk),
    .rst       (rst),
    .port_en   (port_en),
    .div_load  (div_load),
    .wide_mode (wide_mode),
    .fast_mode (fast_mode),
    .div_hi    (div_hi),
    .div_lo    (div_lo),
    .bit_tick  (bit_tick),
    .samp_tick (samp_tick)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // Inputs change just after a rising edge; outputs are read at falling edges.
  task automatic drive_edge();
    @(posedge clk);
    #1;
  endtask

  task automatic pulse_load();
    drive_edge();
    div_load = 1'b1;
    drive_edge();
    div_load = 1'b0;
  endtask

  // Counts falling edges up to the next wanted tick, and the samples seen.
  task automatic wait_tick(input bit want_bit, output int n, output int samps);
    n = 0;
    samps = 0;
    do begin
      @(negedge clk);
      n++;
      if (samp_tick) samps++;
    end while (!(want_bit ? bit_tick : samp_tick) && n < 20000);
  endtask

  task automatic count_quiet(input int cycles, output int ticks);
    ticks = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (bit_tick || samp_tick) ticks++;
    end
  endtask

  task automatic t_reset();
    int t;
    rst = 1'b1; port_en = 1'b1; div_lo = 8'h00;
    count_quiet(6, t);
    chk("R7", "ticks during reset", t, 0);
    drive_edge();
    port_en = 1'b0;
    drive_edge();
    rst = 1'b0;
    count_quiet(20, t);
    chk("R7", "ticks while disabled after reset", t, 0);
  endtask

  task automatic t_enable_narrow();
    int n, s, total;
    drive_edge();
    wide_mode = 1'b0; fast_mode = 1'b1; div_hi = 8'hAB; div_lo = 8'd5;
    drive_edge();
    port_en = 1'b1;
    wait_tick(1'b0, n, s);
    chk("R7", "first sample after enable", n, 6);
    total = n;
    wait_tick(1'b0, n, s);
    chk("R1", "narrow spacing ignores high byte", n, 6);
    total += n;
    wait_tick(1'b1, n, s);
    total += n;
    chk("R7", "first bit after enable", total, 96);
  endtask

  task automatic t_mode(input string tag, input bit w, input bit f,
                        input logic [7:0] hi, input logic [7:0] lo, input int k);
    int n, s, total, d, bitp, sper, spb;
    d    = w ? int'({hi, lo}) : int'(lo);
    bitp = k * (d + 1);
    sper = ((k == 64) ? 4 : 1) * (d + 1);
    spb  = (k == 4) ? 4 : 16;
    drive_edge();
    wide_mode = w; fast_mode = f; div_hi = hi; div_lo = lo;
    pulse_load();
    wait_tick(1'b0, n, s);
    chk("R6", {tag, " first sample after load"}, n, sper);
    total = n;
    wait_tick(1'b0, n, s);
    chk("R4", {tag, " sample spacing"}, n, sper);
    total += n;
    wait_tick(1'b1, n, s);
    total += n;
    chk("R6", {tag, " first bit after load"}, total, bitp);
    wait_tick(1'b1, n, s);
    chk("R2", {tag, " bit period"}, n, bitp);
    chk("R4", {tag, " samples per bit"}, s, spb);
    chk("R5", {tag, " sample at bit tick"}, int'(samp_tick), 1);
    @(negedge clk);
    chk("R3", {tag, " bit tick width"}, int'(bit_tick), 0);
  endtask

  task automatic t_reload_mid();
    int n, s;
    drive_edge();
    wide_mode = 1'b0; fast_mode = 1'b1; div_lo = 8'd20;
    pulse_load();
    repeat (7) @(negedge clk);
    drive_edge();
    div_lo = 8'd3;
    pulse_load();
    wait_tick(1'b0, n, s);
    chk("R6", "sample after mid-period reload", n, 4);
  endtask

  task automatic t_change_no_load();
    int n, s;
    drive_edge();
    wide_mode = 1'b0; fast_mode = 1'b1; div_lo = 8'd10;
    pulse_load();
    wait_tick(1'b0, n, s);
    drive_edge();
    div_lo = 8'd4;
    wait_tick(1'b0, n, s);
    chk("R8", "old period completes", n, 11);
    wait_tick(1'b0, n, s);
    chk("R8", "new period applies", n, 5);
  endtask

  task automatic t_disable();
    int t;
    drive_edge();
    port_en = 1'b0;
    count_quiet(60, t);
    chk("R7", "ticks after disable", t, 0);
  endtask

  initial begin
    t_reset();
    t_enable_narrow();
    t_mode("x64",      1'b0, 1'b0, 8'hFF, 8'd2, 64);
    t_mode("x16 wide", 1'b1, 1'b0, 8'h01, 8'h02, 16);
    t_mode("x4",       1'b1, 1'b1, 8'h00, 8'd9, 4);
    t_mode("x4 d0",    1'b1, 1'b1, 8'h00, 8'd0, 4);
    t_reload_mid();
    t_change_no_load();
    t_disable();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(4 * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule